// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block converts CPU load and store cycles into PCI configuration-space transactions. It offers two ways in. The first is an indirect pair of I/O locations. One 32-bit register holds a routing word: enable, bus, device, function and register. A four-byte data port then issues a transaction for that routing word, with 1, 2 or 4 bytes per access. The second is a 4 MiB memory-mapped window. In the window, the lowest set bit among address bits 11 to 21 names the target device directly. Multi-byte data through the window is byte-reversed to suit a big-endian host.

Each CPU access is held on `cpu_req` until the block pulses `cpu_ack`. The block has one access in flight at a time. It uses a four-state controller. ST_IDLE decodes the access. ST_ISSUE holds the downstream request until it is accepted. ST_WAIT waits for read data. ST_DONE acknowledges the CPU.

The transitions are as follows:
- IDLE→ISSUE for window accesses, and for data-port accesses while the routing word is enabled.
- IDLE→DONE for all locally completed accesses.
- ISSUE→DONE for an accepted write.
- ISSUE→WAIT for an accepted read.
- WAIT→DONE on a response.
- DONE→IDLE always.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the routing register reads as zero, `cpu_ack` and `cfg_req_valid` are low, and no request is pending.
- R2: A 4-byte I/O access (`cpu_io`=1, `cpu_size`=2) at exactly address 0xCF8 writes or reads the 32-bit routing register. Reads return the last value written. Any other size or offset in 0xCF8..0xCFB leaves it unchanged and reads as 0xFFFFFFFF.
- R3: While routing bit 31 is set, an I/O access to 0xCFC..0xCFF issues one downstream request. Its `cfg_addr` is {routing[23:2], cpu_addr[1:0]}. The data is not byte-swapped, and write data is masked to the access size.
- R4: While routing bit 31 is clear, data-port reads return 0xFFFFFFFF and data-port writes complete without any downstream request.
- R5: A memory access (`cpu_io`=0) with an address in 0x8080_0000..0x80BF_FFFF issues one downstream request. Memory addresses outside that range do not.
- R6: For a window access, the device number is the index (counted from bit 11) of the lowest set bit in cpu_addr[21:11], or 11 when none is set. `cfg_addr` is {8'h00, device[4:0], cpu_addr[10:0]}.
- R7: Window write data and read data are byte-reversed: two bytes are swapped for 16-bit accesses, and all four are reversed for 32-bit accesses. 8-bit accesses are unchanged.
- R8: `cfg_req_valid` and the request fields stay stable until `cfg_req_ready`. After acceptance, no second request is made for the same access. Each access ends with a one-cycle `cpu_ack`.
- R9: A downstream read completes only after `cfg_rsp_valid`. `cpu_rdata` is then `cfg_rsp_data` masked to the access size, and reordered as in R7 for window accesses.
- R10: Accesses that match none of the three regions, or that use `cpu_size`=3, complete with read data 0xFFFFFFFF and no downstream request.

`cpu_size` is encoded 0=1 byte, 1=2 bytes, 2=4 bytes. `cfg_size` carries the byte count 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | 32 | CPU address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream request accepted |
| cfg_addr | output | 24 | Configuration address {bus, device, function, register} |
| cfg_size | output | 3 | Byte count 1, 2 or 4 |
| cfg_write | output | 1 | 1 = configuration write |
| cfg_wdata | output | 32 | Write data after masking and lane reordering |
| cfg_rsp_valid | input | 1 | Read response strobe |
| cfg_rsp_data | input | 32 | Read response data, right-aligned |

## Verification
The assertions assume the requester keeps `cpu_req` and its fields steady until `cpu_ack`. They also assume the target raises `cfg_rsp_valid` only while a read is waiting for it, for exactly one cycle. The stimulus meets both conditions. Each CPU access is driven by one task that holds the fields until the acknowledge and drops the request on the same falling edge. That task also plays the target: it grants ready after 0 to 2 cycles and sends a single response only once the request has been accepted.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int CFG_AW = 24;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_AREG,
        ACC_DATA,
        ACC_WIN
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fsm_state_e;

    typedef struct packed {
        logic [CFG_AW-1:0] addr;
        logic [2:0]        nbytes;
        logic              wr;
        logic [31:0]       wdata;
        logic              swap;
    } cfg_cmd_t;

    // size code to byte count; 0 marks an unsupported code
    function automatic logic [2:0] size_to_bytes(logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfgb_lane_swap.sv
module cfgb_lane_swap #(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [31:0] din,
    input  logic [2:0]  nbytes,
    input  logic        swap_en,
    output logic [31:0] dout
);

    logic [31:0] masked;
    logic        do_swap;

    assign do_swap = swap_en && BIG_ENDIAN;

    always_comb begin
        case (nbytes)
            3'd1:    masked = {24'h0, din[7:0]};
            3'd2:    masked = {16'h0, din[15:0]};
            default: masked = din;
        endcase
    end

    always_comb begin
        dout = masked;
        if (do_swap) begin
            case (nbytes)
                3'd2:    dout = {16'h0, masked[7:0], masked[15:8]};
                3'd4:    dout = {masked[7:0], masked[15:8], masked[23:16], masked[31:24]};
                default: dout = masked;
            endcase
        end
    end

endmodule

// File: rtl/cfgb_win_sel.sv
module cfgb_win_sel #(
    parameter int SEL_COUNT = 11,
    parameter int DEV_W     = $clog2(SEL_COUNT + 1)
) (
    input  logic [SEL_COUNT-1:0] sel_bits,
    output logic [DEV_W-1:0]     dev
);

    // lowest set bit wins; scan from the top so lower indices overwrite
    always_comb begin
        dev = DEV_W'(SEL_COUNT);
        for (int i = SEL_COUNT - 1; i >= 0; i--) begin
            if (sel_bits[i]) dev = DEV_W'(i);
        end
    end

endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
    parameter int          WIN_LOG2  = 22,
    parameter int          SEL_LSB   = 11,
    parameter int          SEL_COUNT = 11,
    parameter logic [15:0] AREG_PORT = 16'hCF8,
    parameter logic [15:0] DATA_PORT = 16'hCFC
) (
    input  logic              io,
    input  logic [31:0]       addr,
    input  logic [1:0]        size,
    input  logic [21:0]       route,
    output acc_kind_e         kind,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [2:0]        nbytes
);

    localparam int DEV_W   = $clog2(SEL_COUNT + 1);
    localparam int DEVF_W  = 5;
    localparam int SEL_TOP = SEL_LSB + SEL_COUNT;

    logic [DEV_W-1:0] dev;
    logic             io_low, areg_hit, data_hit, win_hit, size_ok;
    logic [CFG_AW-1:0] win_addr, data_addr;

    cfgb_win_sel #(
        .SEL_COUNT (SEL_COUNT),
        .DEV_W     (DEV_W)
    ) u_sel (
        .sel_bits (addr[SEL_TOP-1:SEL_LSB]),
        .dev      (dev)
    );

    assign nbytes   = size_to_bytes(size);
    assign size_ok  = (nbytes != 3'd0);
    assign io_low   = (addr[31:16] == 16'h0);
    assign areg_hit = io && io_low && (addr[15:0] == AREG_PORT) && (size == 2'd2);
    assign data_hit = io && io_low && (addr[15:2] == DATA_PORT[15:2]) && size_ok;
    assign win_hit  = !io && (addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]) && size_ok;

    assign win_addr  = CFG_AW'({DEVF_W'(dev), addr[SEL_LSB-1:0]});
    assign data_addr = {route, addr[1:0]};

    always_comb begin
        kind     = ACC_NONE;
        cfg_addr = data_addr;
        if (areg_hit) begin
            kind = ACC_AREG;
        end else if (data_hit) begin
            kind = ACC_DATA;
        end else if (win_hit) begin
            kind     = ACC_WIN;
            cfg_addr = win_addr;
        end
    end

    // decoded window device never exceeds the fallback value
    always_comb begin
        AST_DEV_LIMIT: assert (dev <= DEV_W'(SEL_COUNT)); // R6
    end

endmodule

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] d,
    output logic [31:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
    end

    AST_AREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R2

    AST_AREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(d))); // R2

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cfgb_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
    parameter int          WIN_LOG2   = 22,
    parameter int          SEL_LSB    = 11,
    parameter int          SEL_COUNT  = 11,
    parameter logic [15:0] AREG_PORT  = 16'hCF8,
    parameter logic [15:0] DATA_PORT  = 16'hCFC,
    parameter bit          BIG_ENDIAN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_io,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    output logic        cfg_req_valid,
    input  logic        cfg_req_ready,
    output logic [23:0] cfg_addr,
    output logic [2:0]  cfg_size,
    output logic        cfg_write,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_rsp_valid,
    input  logic [31:0] cfg_rsp_data
);

    localparam logic [31:0] ALL_ONES = '1;

    fsm_state_e        state_q, state_d;
    acc_kind_e         kind;
    logic [CFG_AW-1:0] dec_addr;
    logic [2:0]        dec_bytes;
    logic [31:0]       areg_q, wdata_fmt, rdata_fmt, rdata_q;
    logic              areg_we, start, need_issue;
    cfg_cmd_t          cmd_q;

    cfgb_decode #(
        .WIN_BASE  (WIN_BASE),
        .WIN_LOG2  (WIN_LOG2),
        .SEL_LSB   (SEL_LSB),
        .SEL_COUNT (SEL_COUNT),
        .AREG_PORT (AREG_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_dec (
        .io       (cpu_io),
        .addr     (cpu_addr),
        .size     (cpu_size),
        .route    (areg_q[23:2]),
        .kind     (kind),
        .cfg_addr (dec_addr),
        .nbytes   (dec_bytes)
    );

    cfgb_addr_reg u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (areg_we),
        .d     (cpu_wdata),
        .q     (areg_q)
    );

    cfgb_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_wswap (
        .din     (cpu_wdata),
        .nbytes  (dec_bytes),
        .swap_en (kind == ACC_WIN),
        .dout    (wdata_fmt)
    );

    cfgb_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_rswap (
        .din     (cfg_rsp_data),
        .nbytes  (cmd_q.nbytes),
        .swap_en (cmd_q.swap),
        .dout    (rdata_fmt)
    );

    assign start      = (state_q == ST_IDLE) && cpu_req;
    assign need_issue = (kind == ACC_WIN) || ((kind == ACC_DATA) && areg_q[31]);
    assign areg_we    = start && (kind == ACC_AREG) && cpu_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = need_issue ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (cfg_req_ready) state_d = cmd_q.wr ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (cfg_rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // command and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            rdata_q <= '0;
        end else if (start) begin
            cmd_q.addr   <= dec_addr;
            cmd_q.nbytes <= dec_bytes;
            cmd_q.wr     <= cpu_we;
            cmd_q.wdata  <= wdata_fmt;
            cmd_q.swap   <= (kind == ACC_WIN);
            rdata_q      <= (kind == ACC_AREG) ? areg_q : ALL_ONES;
        end else if ((state_q == ST_WAIT) && cfg_rsp_valid) begin
            rdata_q <= rdata_fmt;
        end
    end

    // outputs
    always_comb begin
        cpu_ack       = (state_q == ST_DONE);
        cpu_rdata     = rdata_q;
        cfg_req_valid = (state_q == ST_ISSUE);
        cfg_addr      = cmd_q.addr;
        cfg_size      = cmd_q.nbytes;
        cfg_write     = cmd_q.wr;
        cfg_wdata     = cmd_q.wdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_addr) && $stable(cfg_wdata)); // R8

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R8

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> ($countones(cfg_size) == 1)); // R3

    AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rsp_valid |-> (state_q == ST_WAIT)); // R9

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        start && (kind == ACC_DATA) && !areg_q[31] |=> !cfg_req_valid); // R4

    AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        start && (kind == ACC_NONE) |=> !cfg_req_valid); // R10

    AST_WIN_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cmd_q.swap |-> (cfg_addr[23:16] == 8'h00)); // R6

endmodule

// File: tb/sim_cfg_access_bridge.sv
module sim_cfg_access_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        cfg_req_valid;
    logic        cfg_req_ready = 1'b0;
    logic [23:0] cfg_addr;
    logic [2:0]  cfg_size;
    logic        cfg_write;
    logic [31:0] cfg_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_data = '0;

    int nchecks = 0, nfail = 0;
    bit finished = 0;

    logic [31:0] areg_model = '0;
    bit          got_req, hold_ok, extra_req, acked;
    logic [23:0] r_addr;
    logic [2:0]  r_size;
    logic        r_wr;
    logic [31:0] r_wdata, got_rdata, rsp_sent;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cfg_req_valid(cfg_req_valid),
        .cfg_req_ready(cfg_req_ready), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
        .cfg_write(cfg_write), .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rsp_data(cfg_rsp_data)
    );

    function automatic logic [2:0] nb(logic [1:0] s);
        return (s == 2'd0) ? 3'd1 : (s == 2'd1) ? 3'd2 : (s == 2'd2) ? 3'd4 : 3'd0;
    endfunction

    function automatic logic [31:0] msk(logic [31:0] d, logic [2:0] n);
        return (n == 3'd1) ? {24'h0, d[7:0]} : (n == 3'd2) ? {16'h0, d[15:0]} : d;
    endfunction

    function automatic logic [31:0] swp(logic [31:0] d, logic [2:0] n);
        if (n == 3'd2) return {16'h0, d[7:0], d[15:8]};
        if (n == 3'd4) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return d;
    endfunction

    function automatic logic [4:0] exp_dev(logic [31:0] a);
        for (int i = 0; i < 11; i++) if (a[11+i]) return 5'(i);
        return 5'd11;
    endfunction

    // 0 none, 1 routing register, 2 data port, 3 window
    function automatic int classify(logic io, logic [31:0] a, logic [1:0] s);
        if (io && a[31:16] == 0 && a[15:0] == 16'hCF8 && s == 2'd2) return 1;
        if (io && a[31:16] == 0 && a[15:2] == 14'h33F && s != 2'd3) return 2;
        if (!io && a >= 32'h8080_0000 && a <= 32'h80BF_FFFF && s != 2'd3) return 3;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic io, input logic we, input logic [31:0] a,
                          input logic [1:0] s, input logic [31:0] wd);
        int  wait_req = 0, wait_rsp = 0;
        bit  seen = 0, accepted = 0, responded = 0;
        got_req = 0; hold_ok = 1; extra_req = 0; acked = 0; got_rdata = '0;
        @(negedge clk);
        cpu_io = io; cpu_we = we; cpu_addr = a; cpu_size = s; cpu_wdata = wd; cpu_req = 1'b1;
        for (int k = 0; k < 64 && !acked; k++) begin
            @(negedge clk);
            cfg_req_ready = 1'b0;
            cfg_rsp_valid = 1'b0;
            if (cpu_ack) begin
                acked = 1; got_rdata = cpu_rdata; cpu_req = 1'b0;
            end else begin
                if (cfg_req_valid && !seen) begin
                    seen = 1; got_req = 1; r_addr = cfg_addr; r_size = cfg_size;
                    r_wr = cfg_write; r_wdata = cfg_wdata; wait_req = int'($urandom % 3);
                end else if (cfg_req_valid && accepted) begin
                    extra_req = 1;
                end else if (seen && !accepted &&
                             (!cfg_req_valid || cfg_addr != r_addr || cfg_wdata != r_wdata)) begin
                    hold_ok = 0;
                end
                if (seen && !accepted) begin
                    if (wait_req == 0) begin
                        cfg_req_ready = 1'b1; accepted = 1; wait_rsp = int'($urandom % 3);
                    end else wait_req--;
                end else if (accepted && !r_wr && !responded) begin
                    if (wait_rsp == 0) begin
                        cfg_rsp_data = $urandom; rsp_sent = cfg_rsp_data;
                        cfg_rsp_valid = 1'b1; responded = 1;
                    end else wait_rsp--;
                end
            end
        end
        if (!acked) begin
            cpu_req = 1'b0;
            chk(0, "R8 no acknowledge", 32'(acked), 32'd1);
        end
    endtask

    task automatic run(input logic io, input logic we, input logic [31:0] a,
                       input logic [1:0] s, input logic [31:0] wd);
        int          k = classify(io, a, s);
        logic [2:0]  n = nb(s);
        bit          expect_req = (k == 3) || (k == 2 && areg_model[31]);
        logic [23:0] ea;
        access(io, we, a, s, wd);
        if (expect_req) begin
            chk(got_req, (k == 3) ? "R5 window request missing" : "R3 data request missing",
                32'(got_req), 32'd1);
            if (got_req) begin
                ea = (k == 3) ? {8'h00, exp_dev(a), a[10:0]} : {areg_model[23:2], a[1:0]};
                chk(r_addr == ea, (k == 3) ? "R6 window address" : "R3 data address",
                    32'(r_addr), 32'(ea));
                chk(r_size == n && r_wr == we, "R3 size/write flag",
                    {r_size, 3'b0, r_wr}, {n, 3'b0, we});
                chk(hold_ok && !extra_req, "R8 request hold", 32'(hold_ok), 32'd1);
                if (we)
                    chk(r_wdata == ((k == 3) ? swp(msk(wd, n), n) : msk(wd, n)),
                        (k == 3) ? "R7 window write data" : "R3 data write",
                        r_wdata, (k == 3) ? swp(msk(wd, n), n) : msk(wd, n));
                else
                    chk(got_rdata == ((k == 3) ? swp(msk(rsp_sent, n), n) : msk(rsp_sent, n)),
                        (k == 3) ? "R7 window read data" : "R9 read data",
                        got_rdata, (k == 3) ? swp(msk(rsp_sent, n), n) : msk(rsp_sent, n));
            end
        end else begin
            chk(!got_req, (k == 2) ? "R4 disabled request" : (k == 1) ? "R2 local request" :
                "R10 unmapped request", 32'(got_req), 32'd0);
            if (!we)
                chk(got_rdata == ((k == 1) ? areg_model : 32'hFFFF_FFFF),
                    (k == 1) ? "R2 routing readback" : (k == 2) ? "R4 disabled read" : "R10 unmapped read",
                    got_rdata, (k == 1) ? areg_model : 32'hFFFF_FFFF);
            if (k == 1 && we) areg_model = wd;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ack && !cfg_req_valid, "R1 idle outputs", {cpu_ack, cfg_req_valid}, 32'd0);
        access(1'b1, 1'b0, 32'h0CF8, 2'd2, '0);
        chk(got_rdata == 32'h0 && !got_req, "R1 routing reset value", got_rdata, 32'h0);

        run(1'b1, 1'b0, 32'h0CFC, 2'd2, '0);              // R4 read, enable clear
        run(1'b1, 1'b1, 32'h0CFD, 2'd0, 32'h55);          // R4 write, enable clear
        run(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8012_3456);   // R2
        run(1'b1, 1'b0, 32'h0CF8, 2'd2, '0);              // R2 readback
        run(1'b1, 1'b1, 32'h0CF8, 2'd1, 32'h0000_FFFF);   // R2 short write ignored
        run(1'b1, 1'b1, 32'h0CF9, 2'd2, 32'h1111_1111);   // R2 offset write ignored
        run(1'b1, 1'b0, 32'h0CF8, 2'd2, '0);              // R2 unchanged
        run(1'b1, 1'b0, 32'h0CFE, 2'd0, '0);              // R3 byte read
        run(1'b1, 1'b1, 32'h0CFC, 2'd1, 32'hABCD_1234);   // R3 half write
        run(1'b1, 1'b0, 32'h0CFC, 2'd2, '0);              // R3 word read
        run(1'b0, 1'b1, 32'h8080_0123, 2'd2, 32'h1122_3344); // R6 device 11, R7
        run(1'b0, 1'b0, 32'h80A0_0004, 2'd1, '0);         // R6 bit 21 only
        run(1'b0, 1'b0, 32'h8080_A7FC, 2'd2, '0);         // R6 bits 13 and 15
        run(1'b0, 1'b1, 32'h80BF_FFFF, 2'd0, 32'h0000_00A5); // R5 top, R7 byte
        run(1'b0, 1'b0, 32'h80C0_0000, 2'd2, '0);         // R10 above window
        run(1'b0, 1'b0, 32'h807F_FFFC, 2'd2, '0);         // R10 below window
        run(1'b1, 1'b0, 32'h0CF4, 2'd2, '0);              // R10 other I/O
        run(1'b1, 1'b0, 32'h8080_0000, 2'd2, '0);         // R10 window address as I/O
        run(1'b0, 1'b0, 32'h8080_1000, 2'd3, '0);         // R10 bad size

        for (int t = 0; t < 400; t++) begin
            logic        io = 1'($urandom % 2);
            logic        we = 1'($urandom % 2);
            logic [1:0]  s  = 2'($urandom % 4);
            logic [31:0] a;
            logic [31:0] wd = $urandom;
            if (io) begin
                a = ($urandom % 8 == 0) ? ($urandom & 32'h0000_FFFC) : (32'h0CF8 + ($urandom % 8));
                if (a == 32'h0CF8 && ($urandom % 2 == 1)) s = 2'd2;
            end else begin
                a = ($urandom % 6 == 0) ? $urandom
                    : (32'h8080_0000 | ($urandom & 32'h0000_07FF) | (32'(1) << (11 + ($urandom % 12))));
            end
            run(io, we, a, s, wd);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule